// File: doc/BRIEF.md
# Interrupt Class Delivery Controller

This block sequences interrupt delivery for one processor core. Seven interrupt classes feed it a pending level each. A wake-up pulse starts a delivery chain. The controller picks one pending class at a time by fixed priority and raises that class's start strobe to a separate entry unit. It then waits for the unit's done pulse and looks at the pending levels again. The chain ends when nothing is pending or when a stop has been delivered.

At the end of each chain the controller makes one decision about the core's run state: ask it to halt, release it from halt, or leave it alone. Two other rules apply. While the target of an execute-type instruction is still running, no new delivery may begin. When a supervisor-call delivery finishes while a debug event is pending, a program-class delivery follows at once and tells its entry unit to use the supervisor-call instruction length.

The entry units do the state save and reload work. The interrupt sources are not part of this block.

Top module: `irq_chain_ctrl`

## Requirements
- R1: After reset, all start strobes are low, the halt and release pulses are low, and the request flag is low.
- R2: Pending bits are indexed as 0 program, 1 supervisor call, 2 machine check, 3 external, 4 I/O, 5 restart, 6 stop. When several are pending, the lowest index is delivered first.
- R3: At most one start strobe is high at any time. A strobe stays high and unchanged until the done bit of the same index arrives.
- R4: When a delivery other than stop completes, the controller samples the pending bits again and starts the next class. This repeats until no bit is pending.
- R5: A completed stop delivery ends the chain at once. A class that became pending during the stop delivery is not delivered in that chain.
- R6: When a chain ends, the halt pulse fires if the wait bit is set or a stop was delivered. Otherwise the release pulse fires if the core reports halted. Otherwise neither pulse fires.
- R7: While the execute-busy input is high, no start strobe rises.
- R8: A wake-up with nothing pending and the wait bit set produces a halt pulse and no start strobe.
- R9: When a supervisor-call delivery completes while the debug input is high, the next cycle raises the program strobe (bit 0) together with the supervisor-length flag.
- R10: The request flag is set by a wake-up. It is cleared at the end of a chain only if no class is then pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pend_i | input | 7 | Pending level per class (index order as in R2) |
| dbg_pend_i | input | 1 | Debug event pending |
| wait_psw_i | input | 1 | Current status word has the wait bit set |
| halted_i | input | 1 | Core is currently halted |
| exec_busy_i | input | 1 | Target of an execute-type instruction in progress |
| kick_i | input | 1 | Wake-up pulse that starts a delivery chain |
| done_i | input | 7 | Completion pulse per class entry unit |
| start_o | output | 7 | Start strobe per class, one-hot or zero |
| pgm_svc_len_o | output | 1 | Program delivery must use supervisor-call length |
| halt_o | output | 1 | One-cycle halt request |
| unhalt_o | output | 1 | One-cycle release-from-halt request |
| irq_req_o | output | 1 | Interrupt request still outstanding |

## Verification
The bench raises several classes together and checks that they are delivered one per chain step in priority order. A design that picked the wrong class, or returned to idle after the first delivery, would show up as out-of-order or missing strobes. It also checks the supervisor-call-then-program chaining with the length flag, and that a class arriving during a stop delivery is held back with the request flag still set. Execute-busy is held across a wake-up to catch a controller that ignores it. Halt, release and no-action endings are each exercised, including a bare wake-up with the wait bit set.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
    localparam int NCLS  = 7;
    localparam int CLS_W = $clog2(NCLS);

    typedef enum logic [CLS_W-1:0] {
        CLS_PGM     = 3'd0,
        CLS_SVC     = 3'd1,
        CLS_MCHK    = 3'd2,
        CLS_EXT     = 3'd3,
        CLS_IO      = 3'd4,
        CLS_RESTART = 3'd5,
        CLS_STOP    = 3'd6
    } cls_e;

    typedef enum logic [1:0] {
        ST_IDLE, ST_ARB, ST_DELIVER, ST_FINISH
    } st_e;

    typedef struct packed {
        cls_e cls;
        logic svc_len;
        logic stopped;
    } chain_t;

    function automatic logic [NCLS-1:0] cls_onehot(cls_e c);
        return NCLS'(1) << c;
    endfunction
endpackage

// File: rtl/irq_pick.sv
module irq_pick
    import irq_chain_pkg::*;
(
    input  logic [NCLS-1:0] pend,
    output logic            any,
    output cls_e            pick
);
    // lowest index wins
    always_comb begin
        pick = CLS_PGM;
        for (int i = NCLS - 1; i >= 0; i--) begin
            if (pend[i]) pick = cls_e'(CLS_W'(i));
        end
    end
    assign any = |pend;
endmodule

// File: rtl/irq_end_policy.sv
module irq_end_policy (
    input  logic fire,
    input  logic wait_psw,
    input  logic stopped,
    input  logic halted,
    output logic halt,
    output logic unhalt
);
    always_comb begin
        halt   = 1'b0;
        unhalt = 1'b0;
        if (fire) begin
            if (wait_psw || stopped) halt = 1'b1;
            else if (halted)         unhalt = 1'b1;
        end
    end
endmodule

// File: rtl/irq_chain_ctrl.sv
module irq_chain_ctrl
    import irq_chain_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [NCLS-1:0] pend_i,
    input  logic            dbg_pend_i,
    input  logic            wait_psw_i,
    input  logic            halted_i,
    input  logic            exec_busy_i,
    input  logic            kick_i,
    input  logic [NCLS-1:0] done_i,
    output logic [NCLS-1:0] start_o,
    output logic            pgm_svc_len_o,
    output logic            halt_o,
    output logic            unhalt_o,
    output logic            irq_req_o
);
    st_e    st_q;
    chain_t ch_q;
    logic   req_q;
    logic   any_pend;
    cls_e   pick;

    irq_pick pick_i (
        .pend (pend_i),
        .any  (any_pend),
        .pick (pick)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            ch_q  <= '0;
            req_q <= 1'b0;
        end else begin
            case (st_q)
                ST_IDLE: begin
                    if (kick_i) begin
                        st_q         <= ST_ARB;
                        ch_q.stopped <= 1'b0;
                        ch_q.svc_len <= 1'b0;
                    end
                end
                ST_ARB: begin
                    if (!exec_busy_i) begin
                        if (any_pend) begin
                            ch_q.cls     <= pick;
                            ch_q.svc_len <= 1'b0;
                            st_q         <= ST_DELIVER;
                        end else begin
                            st_q <= ST_FINISH;
                        end
                    end
                end
                ST_DELIVER: begin
                    if (done_i[ch_q.cls]) begin
                        if (ch_q.cls == CLS_STOP) begin
                            ch_q.stopped <= 1'b1;
                            st_q         <= ST_FINISH;
                        end else if (ch_q.cls == CLS_SVC && dbg_pend_i) begin
                            ch_q.cls     <= CLS_PGM;
                            ch_q.svc_len <= 1'b1;
                        end else begin
                            st_q <= ST_ARB;
                        end
                    end
                end
                default: begin
                    if (!any_pend) req_q <= 1'b0;
                    st_q <= ST_IDLE;
                end
            endcase
            if (kick_i) req_q <= 1'b1;
        end
    end

    assign start_o       = (st_q == ST_DELIVER) ? cls_onehot(ch_q.cls) : '0;
    assign pgm_svc_len_o = (st_q == ST_DELIVER) && ch_q.svc_len;
    assign irq_req_o     = req_q;

    irq_end_policy end_i (
        .fire     (st_q == ST_FINISH),
        .wait_psw (wait_psw_i),
        .stopped  (ch_q.stopped),
        .halted   (halted_i),
        .halt     (halt_o),
        .unhalt   (unhalt_o)
    );
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk
    import irq_chain_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            dbg_pend_i,
    input logic            exec_busy_i,
    input logic [NCLS-1:0] done_i,
    input logic [NCLS-1:0] start_o,
    input logic            pgm_svc_len_o,
    input logic            halt_o,
    input logic            unhalt_o
);
    // R3: never two strobes
    p_onehot_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(start_o));

    // R3: strobe held until its done arrives
    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (|start_o && !(|(start_o & done_i))) |=> $stable(start_o));

    // R7: no strobe rises while execute-busy
    p_exec_block_r7: assert property (@(posedge clk) disable iff (rst)
        (exec_busy_i && start_o == '0) |=> start_o == '0);

    // R5: stop completion ends the chain
    p_stop_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (start_o[CLS_STOP] && done_i[CLS_STOP]) |=> (start_o == '0 && halt_o));

    // R9: supervisor call with debug chains to program with length flag
    p_svc_chain_r9: assert property (@(posedge clk) disable iff (rst)
        (start_o[CLS_SVC] && done_i[CLS_SVC] && dbg_pend_i)
            |=> (start_o == cls_onehot(CLS_PGM) && pgm_svc_len_o));

    // R4: ordinary completion returns to arbitration
    p_rearb_r4: assert property (@(posedge clk) disable iff (rst)
        ((|(start_o & done_i)) && !start_o[CLS_STOP]
            && !(start_o[CLS_SVC] && dbg_pend_i)) |=> start_o == '0);

    // R6: halt and release are exclusive
    p_end_excl_r6: assert property (@(posedge clk) disable iff (rst)
        !(halt_o && unhalt_o));
endmodule

bind irq_chain_ctrl irq_chain_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .dbg_pend_i    (dbg_pend_i),
    .exec_busy_i   (exec_busy_i),
    .done_i        (done_i),
    .start_o       (start_o),
    .pgm_svc_len_o (pgm_svc_len_o),
    .halt_o        (halt_o),
    .unhalt_o      (unhalt_o)
);

// File: tb/irq_chain_ctrl_tb.sv
module irq_chain_ctrl_tb_top;
    import irq_chain_pkg::*;

    localparam int LAT = 2;
    localparam int EV_HALT = 7;
    localparam int EV_UNHALT = 8;
    localparam int EV_PGM_SVC = 9;

    typedef struct {
        int    code;
        string tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [NCLS-1:0] pend = '0;
    logic            dbg = 1'b0;
    logic            wait_psw = 1'b0;
    logic            halted = 1'b0;
    logic            exec_busy = 1'b0;
    logic            kick = 1'b0;
    logic [NCLS-1:0] done = '0;
    logic [NCLS-1:0] start;
    logic            svc_len, halt, unhalt, irq_req;

    int   errors = 0;
    int   checks = 0;
    exp_t q[$];
    logic raise_on_stop = 1'b0;

    always #4 clk = ~clk;

    irq_chain_ctrl dut_i (
        .clk           (clk),
        .rst           (rst),
        .pend_i        (pend),
        .dbg_pend_i    (dbg),
        .wait_psw_i    (wait_psw),
        .halted_i      (halted),
        .exec_busy_i   (exec_busy),
        .kick_i        (kick),
        .done_i        (done),
        .start_o       (start),
        .pgm_svc_len_o (svc_len),
        .halt_o        (halt),
        .unhalt_o      (unhalt),
        .irq_req_o     (irq_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic expect_ev(input int code, input string tag);
        exp_t e;
        e.code = code;
        e.tag  = tag;
        q.push_back(e);
    endtask

    // entry-unit model: completes after LAT cycles, retires the pending bit
    int rcnt = 0;
    always @(negedge clk) begin
        if (done != '0) begin
            done <= '0;
            rcnt <= 0;
        end else if (start != '0) begin
            if (rcnt + 1 == LAT) begin
                done <= start;
                pend <= (pend & ~start) | ((start[CLS_STOP] && raise_on_stop) ? 7'b0001000 : 7'b0);
                if (start[CLS_PGM] && svc_len) dbg <= 1'b0;
            end
            rcnt <= rcnt + 1;
        end else begin
            rcnt <= 0;
        end
    end

    // monitor: turns output activity into events and compares with the queue
    logic [NCLS-1:0] prev_start = '0;
    task automatic got(input int code);
        exp_t e;
        if (q.size() == 0) begin
            check(1'b0, "unexpected event", code, -1);
        end else begin
            e = q.pop_front();
            check(e.code == code, e.tag, code, e.code);
        end
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (start != prev_start && start != '0) begin
                int idx = 0;
                for (int i = 0; i < NCLS; i++) if (start[i]) idx = i;
                got((idx == 0 && svc_len) ? EV_PGM_SVC : idx);
            end
            if (halt)   got(EV_HALT);
            if (unhalt) got(EV_UNHALT);
            prev_start = start;
        end
    end

    task automatic run_chain();
        int guard = 0;
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        while (q.size() != 0 && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        repeat (4) @(negedge clk);
        check(q.size() == 0, "chain incomplete", q.size(), 0);
        q.delete();
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            check(1'b0, "watchdog", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(start == '0, "R1 start", int'(start), 0);
        check(!halt && !unhalt, "R1 halt/unhalt", int'({halt, unhalt}), 0);
        check(!irq_req, "R1 irq_req", int'(irq_req), 0);

        // R2 R4 R6 R10: three classes, halted core released
        halted = 1'b1;
        pend = 7'b0011100;
        expect_ev(2, "R2 first machine check");
        expect_ev(3, "R4 then external");
        expect_ev(4, "R4 then I/O");
        expect_ev(EV_UNHALT, "R6 release halted core");
        run_chain();
        check(!irq_req, "R10 cleared when empty", int'(irq_req), 0);

        // R2 R6: program before restart, wait bit gives halt
        halted = 1'b0;
        wait_psw = 1'b1;
        pend = 7'b0100001;
        expect_ev(0, "R2 program first");
        expect_ev(5, "R4 restart next");
        expect_ev(EV_HALT, "R6 halt on wait bit");
        run_chain();

        // R9: supervisor call chains into program with its length; R6 no action
        wait_psw = 1'b0;
        pend = 7'b0000010;
        dbg = 1'b1;
        expect_ev(1, "R9 supervisor call");
        expect_ev(EV_PGM_SVC, "R9 program with svc length");
        run_chain();

        // R7: execute-busy blocks delivery
        pend = 7'b0010000;
        exec_busy = 1'b1;
        @(negedge clk) kick = 1'b1;
        @(negedge clk) kick = 1'b0;
        repeat (10) @(negedge clk);
        check(start == '0, "R7 blocked while busy", int'(start), 0);
        check(irq_req, "R10 set by wake-up", int'(irq_req), 1);
        expect_ev(4, "R7 delivered after busy drops");
        exec_busy = 1'b0;
        repeat (10) @(negedge clk);
        check(q.size() == 0, "R7 delivery after release", q.size(), 0);
        q.delete();

        // R8: wake-up with nothing pending and wait bit set
        wait_psw = 1'b1;
        expect_ev(EV_HALT, "R8 back to halt");
        run_chain();

        // R5 R10: stop ends chain; external arriving meanwhile is held
        wait_psw = 1'b0;
        raise_on_stop = 1'b1;
        pend = 7'b1000000;
        expect_ev(6, "R5 stop delivered");
        expect_ev(EV_HALT, "R5 halt after stop");
        run_chain();
        raise_on_stop = 1'b0;
        check(pend == 7'b0001000, "R5 external left pending", int'(pend), 8);
        check(irq_req, "R10 stays set with pending", int'(irq_req), 1);
        halted = 1'b1;
        expect_ev(3, "R5 external on next chain");
        expect_ev(EV_UNHALT, "R6 release after chain");
        run_chain();
        check(!irq_req, "R10 cleared at end", int'(irq_req), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule